// File: doc/BRIEF.md
# Serial Bus Frame Sync Generator

This block produces the two timing signals of a time-division serial bus: a data clock and an 8 kHz frame sync. Both are always outputs; the block never follows an external clock. A free-running divider splits the 16.384 MHz system clock into the data clock. A second counter splits that clock into frames. With the default parameters the data clock runs at 4.096 MHz and each frame lasts 512 data-clock periods.

In an ordinary frame the sync is a square wave: high for the first half of the frame and low for the second half. A frame can instead carry a multiframe marker. In a marker frame the sync is high for only the first data-clock period and low for the rest of the frame. The frame after a marker frame is always ordinary.

Markers are produced in two ways. A pulse on the request input asks for one marker at the next eligible frame boundary. A nonzero period setting asks for a marker every N frames. Two one-cycle strobes in the system clock domain mark each frame start and each marker frame start.

Top module: `fsync_gen`

## Requirements
- R1: While `rst_n` is low, or `en` was sampled low at the last clock edge, `dcl`, `fsc`, `frame_start` and `mf_start` are low. The pending request and the frame counter are cleared, so a `mf_req` pulse received while disabled has no effect.
- R2: `dcl` has a period of CLK_DIV system clocks. It is high for the first CLK_DIV/2 of them. Its first rising edge appears at the first clock edge that samples `en` high.
- R3: A frame lasts FRAME_DCL periods of `dcl`. In an ordinary frame `fsc` is high for the first FRAME_DCL/2 periods and low for the rest.
- R4: `fsc` changes level only together with a rising edge of `dcl`, except when the block is being disabled.
- R5: `frame_start` is high for exactly one system clock at the start of every frame, in the same cycle that `fsc` and `dcl` rise.
- R6: In a marker frame `fsc` is high for exactly one `dcl` period (CLK_DIV system clocks). `mf_start` is high in that frame's `frame_start` cycle and never at any other time.
- R7: A `mf_req` pulse sampled before a frame's start cycle makes that frame a marker frame, if it is eligible; otherwise the request stays pending until the next eligible frame. Several pulses before one marker yield a single marker.
- R8: `mf_period` = N, with N from 1 to MF_MAX, makes a frame a marker frame when at least N frame starts have occurred since the last marker frame started. The count runs from enable when no marker has occurred yet, so the first periodic marker is frame N, counting from frame 0. `mf_period` = 0 disables periodic markers.
- R9: The first frame after enable is never a marker frame. The frame after a marker frame is never a marker frame.
- R10: A `mf_period` value above MF_MAX never produces a periodic marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the outputs low and restarts the frame |
| mf_req | input | 1 | Request a multiframe marker at the next eligible frame |
| mf_period | input | $clog2(MF_MAX+1) | Periodic marker spacing in frames; 0 disables |
| dcl | output | 1 | Data clock |
| fsc | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle strobe at each frame start |
| mf_start | output | 1 | One-cycle strobe at each marker frame start |

## Verification
The bench builds the block with CLK_DIV = 4 and FRAME_DCL = 16, so one frame takes only 64 system clocks. This keeps the default MF_MAX = 64 within reach: the 64-frame period and an out-of-range period of 100 both run over more than sixty frames in a short run. Forced-normal frames after markers and requests that arrive during a marker frame can then be observed over many frames.

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int CLK_DIV   = 4,
  parameter int FRAME_DCL = 512,
  parameter int MF_MAX    = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        mf_req,
  input  logic [$clog2(MF_MAX+1)-1:0] mf_period,
  output logic                        dcl,
  output logic                        fsc,
  output logic                        frame_start,
  output logic                        mf_start
);
  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int FW = $clog2(FRAME_DCL);
  localparam int PW = $clog2(MF_MAX + 1);
  localparam int HALF_DIV   = CLK_DIV / 2;
  localparam int HALF_FRAME = FRAME_DCL / 2;

  logic          run, mk, pend;
  logic [DW-1:0] div, div_n;
  logic [FW-1:0] bitc, bit_n;
  logic [PW-1:0] fcnt;

  logic div_last, bit_last, bnd, mk_new, mk_n;

  assign div_last = (div == DW'(CLK_DIV - 1));
  assign bit_last = (bitc == FW'(FRAME_DCL - 1));
  assign bnd      = !run || (div_last && bit_last);
  assign mk_new   = run && !mk && (pend || ((mf_period != '0) && (fcnt >= mf_period)));
  assign mk_n     = bnd ? mk_new : mk;

  always_comb begin
    div_n = (!run || div_last) ? '0 : div + 1'b1;
    if (!run)
      bit_n = '0;
    else if (div_last)
      bit_n = bit_last ? '0 : bitc + 1'b1;
    else
      bit_n = bitc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; div <= '0; bitc <= '0; mk <= 1'b0; pend <= 1'b0; fcnt <= '0;
      dcl <= 1'b0; fsc <= 1'b0; frame_start <= 1'b0; mf_start <= 1'b0;
    end else if (!en) begin
      run <= 1'b0; div <= '0; bitc <= '0; mk <= 1'b0; pend <= 1'b0; fcnt <= '0;
      dcl <= 1'b0; fsc <= 1'b0; frame_start <= 1'b0; mf_start <= 1'b0;
    end else begin
      run         <= 1'b1;
      div         <= div_n;
      bitc        <= bit_n;
      mk          <= mk_n;
      pend        <= (pend && !(bnd && mk_new)) || mf_req;
      if (bnd)
        fcnt <= mk_new ? PW'(1) : ((fcnt == PW'(MF_MAX)) ? fcnt : fcnt + 1'b1);
      dcl         <= (div_n < DW'(HALF_DIV));
      fsc         <= mk_n ? (bit_n == '0) : (bit_n < FW'(HALF_FRAME));
      frame_start <= bnd;
      mf_start    <= bnd && mk_new;
    end
  end
endmodule

// File: rtl/fsync_gen_chk.sv
module fsync_gen_chk #(
  parameter int CLK_DIV   = 4,
  parameter int FRAME_DCL = 512
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic dcl,
  input logic fsc,
  input logic frame_start,
  input logic mf_start
);
  int   hi_len;
  logic mk_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len  <= 0;
      mk_seen <= 1'b0;
    end else begin
      hi_len  <= fsc ? hi_len + 1 : 0;
      mk_seen <= fsc ? (mk_seen || mf_start) : 1'b0;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!dcl && !fsc && !frame_start && !mf_start)); // R1
  AST_FS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (fsc && dcl)); // R5
  AST_FS_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R5
  AST_MF_IN_FS: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> frame_start); // R6
  AST_FSC_RISE_DCL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsc) |-> $rose(dcl)); // R4
  AST_FSC_FALL_DCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fsc) && $past(en)) |-> $rose(dcl)); // R4
  AST_MARKER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fsc) && $past(en) && mk_seen) |-> (hi_len == CLK_DIV)); // R6
  AST_NORMAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fsc) && $past(en) && !mk_seen) |-> (hi_len == CLK_DIV * FRAME_DCL / 2)); // R3
endmodule

bind fsync_gen fsync_gen_chk #(.CLK_DIV(CLK_DIV), .FRAME_DCL(FRAME_DCL)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dcl(dcl), .fsc(fsc),
  .frame_start(frame_start), .mf_start(mf_start)
);

// File: tb/fsync_gen_tb.sv
`timescale 1ns/1ps
module fsync_gen_tb;
  localparam int CD = 4, FD = 16, MM = 64, FSYS = CD * FD;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, mf_req = 1'b0;
  logic [6:0] per = '0;
  logic dcl, fsc, fs, mf;
  int tests = 0, fails = 0, mf_cnt = 0, fs_cnt = 0;
  bit done = 0;

  fsync_gen #(.CLK_DIV(CD), .FRAME_DCL(FD), .MF_MAX(MM)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mf_req(mf_req), .mf_period(per),
    .dcl(dcl), .fsc(fsc), .frame_start(fs), .mf_start(mf));

  always #2 clk = ~clk;

  int m_t = 0, m_fcnt = 0;
  bit m_run = 0, m_mk = 0, m_pend = 0;
  bit e_dcl = 0, e_fsc = 0, e_fs = 0, e_mf = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_run = 0; m_t = 0; m_pend = 0; m_fcnt = 0; m_mk = 0;
      e_dcl = 0; e_fsc = 0; e_fs = 0; e_mf = 0;
    end else begin
      bit bnd, first, take;
      int pos, bn;
      bnd = 0; first = 0; take = 0;
      if (!m_run) begin m_run = 1; m_t = 0; bnd = 1; first = 1; end
      else begin m_t++; bnd = (m_t % FSYS == 0); end
      if (bnd) begin
        take = !first && !m_mk && (m_pend || (per != 0 && m_fcnt >= int'(per)));
        m_mk = take;
        m_fcnt = take ? 1 : (m_fcnt < MM ? m_fcnt + 1 : m_fcnt);
      end
      m_pend = (m_pend && !take) || mf_req;
      pos = m_t % FSYS; bn = pos / CD;
      e_dcl = (pos % CD) < CD / 2;
      e_fsc = m_mk ? (bn == 0) : (bn < FD / 2);
      e_fs = bnd; e_mf = take;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(dcl == e_dcl, "R2 dcl", dcl, e_dcl);
    chk(fsc == e_fsc, "R3 fsc", fsc, e_fsc);
    chk(fs == e_fs, "R5 frame_start", fs, e_fs);
    chk(mf == e_mf, "R6 mf_start", mf, e_mf);
    if (mf) mf_cnt++;
    if (fs) fs_cnt++;
  end

  task automatic quiet(input string tag);
    chk(!dcl && !fsc && !fs && !mf, tag, {dcl, fsc, fs, mf}, 0);
  endtask

  task automatic restart();
    @(negedge clk); en = 1'b0;
    repeat (3) @(negedge clk);
    #1 quiet("R1 disabled outputs low");
    @(negedge clk); en = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); mf_req = 1'b1;
    @(negedge clk); mf_req = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b, f;
    cyc(5);
    #1 quiet("R1 reset outputs low");
    rst_n = 1'b1;
    pulse();
    cyc(4);
    #1 quiet("R1 request while disabled");

    // ordinary frames, no markers; enable at negedge, frame 0 starts next posedge
    per = 0;
    @(negedge clk); en = 1'b1;
    #1 b = mf_cnt; f = fs_cnt;
    cyc(4 * FSYS);
    #1 chk(mf_cnt - b == 0, "R8 period zero no marker", mf_cnt - b, 0);
    chk(fs_cnt - f == 4, "R5 one strobe per frame", fs_cnt - f, 4);

    // request during a frame; two pulses merge into one marker
    restart();
    #1 b = mf_cnt;
    cyc(FSYS + 10); pulse(); pulse();
    cyc(4 * FSYS);
    #1 chk(mf_cnt - b == 1, "R7 merged request", mf_cnt - b, 1);

    // request in frame 0 and again in the marker frame 1 -> markers at frames 1 and 3
    restart();
    #1 b = mf_cnt;
    cyc(5); pulse();
    cyc(FSYS + 10); pulse();
    cyc(3 * FSYS);
    #1 chk(mf_cnt - b == 2, "R9 frame after marker forced normal", mf_cnt - b, 2);

    // period 3 over 12 frames -> frames 3,6,9
    per = 3;
    restart();
    #1 b = mf_cnt;
    cyc(12 * FSYS - 1);
    #1 chk(mf_cnt - b == 3, "R8 period three", mf_cnt - b, 3);

    // period 1 over 8 frames -> frames 1,3,5,7; frame 0 normal
    per = 1;
    restart();
    #1 b = mf_cnt;
    cyc(FSYS - 1);
    #1 chk(mf_cnt - b == 0, "R9 first frame normal", mf_cnt - b, 0);
    cyc(7 * FSYS);
    #1 chk(mf_cnt - b == 4, "R8 period one", mf_cnt - b, 4);

    // period 64 over 130 frames -> frames 64,128
    per = 64;
    restart();
    #1 b = mf_cnt;
    cyc(130 * FSYS - 1);
    #1 chk(mf_cnt - b == 2, "R8 period at maximum", mf_cnt - b, 2);

    // period above maximum
    per = 100;
    restart();
    #1 b = mf_cnt;
    cyc(70 * FSYS);
    #1 chk(mf_cnt - b == 0, "R10 period out of range", mf_cnt - b, 0);

    // disable mid-frame, then request while disabled is dropped
    per = 0;
    cyc(FSYS / 2 + 3);
    @(negedge clk); en = 1'b0;
    pulse();
    cyc(2);
    #1 quiet("R1 disable mid frame");
    @(negedge clk); en = 1'b1;
    #1 b = mf_cnt;
    cyc(3 * FSYS);
    #1 chk(mf_cnt - b == 0, "R1 request dropped while disabled", mf_cnt - b, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule